// File: doc/BRIEF.md
# Exception Priority and Entry Unit

This block holds the exception-entry state of a small 32-bit RISC core. Seven request lines, one per exception kind, are gated by the interrupt-disable bits of the current status word. The surviving requests are reduced to one winner by a fixed ranking. In a single clock edge the unit then does five things. It stores the current status word in the saved-status register banked for the target mode. It moves the status word to that mode and forces the 32-bit instruction state. It raises the interrupt masks. It records the caller-supplied return address in the link register banked for that mode. It points the program counter at the exception's vector slot.

The unit also carries out the exception-return operation. On return, the status word comes back from the saved-status register of the current mode and the program counter is loaded from that mode's link register. A plain status write port models the core's move-to-status instruction, so software can change modes and clear masks. Instruction decode, the general register file and the pipeline lie outside this block.

Status word layout (8 bits): bit 7 is I (IRQ disable), bit 6 is F (FIQ disable), bit 5 is T (alternate instruction state; entry forces 0), and bits 4:0 are the mode. The mode codes are: user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011. Request and index numbering, from highest to lowest priority: 0 reset, 1 data abort, 2 FIQ, 3 IRQ, 4 prefetch abort, 5 undefined instruction, 6 software interrupt.

Top module: `exc_entry_unit`

## Requirements
- R1: While rst_ni is low and right after it is released, taken_o is 0, pc_o equals VEC_BASE, and psr_o is user mode with I, F and T all 0 (8'h10).
- R2: When several unmasked requests are present, the winner is the one with the lowest index. exc_idx_o carries that index in the cycle where taken_o is 1.
- R3: Request 3 (IRQ) is ignored while psr_o bit 7 is 1. Request 2 (FIQ) is ignored while psr_o bit 6 is 1. No other request is ever masked, and reset in particular is never masked.
- R4: On entry, pc_o becomes VEC_BASE plus the slot offset. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R5: On entry, the mode becomes the exception's mode (supervisor for reset and software interrupt, abort for both aborts, FIQ, IRQ, undefined), T becomes 0 and I becomes 1. F becomes 1 for reset and FIQ and is left unchanged otherwise.
- R6: On entry, the status word held before the entry is saved in the bank of the target mode. A later return made in that mode restores exactly that word to psr_o.
- R7: On entry, link_addr_i is saved in the bank of the target mode. A return made in that mode loads that value into pc_o.
- R8: Both an entry and a return take effect on the first clock edge that samples the request. taken_o is high for exactly the cycles that follow an edge which sampled an unmasked request, and it is low otherwise.
- R9: A return requested in user mode, or in any mode without a bank, leaves psr_o and pc_o unchanged. An entry sampled at the same edge as a return takes precedence over the return.
- R10: With no entry and no effective return, psr_we_i loads psr_wdata_i into psr_o. A status write never changes pc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 7 | Exception requests, bit n is index n |
| link_addr_i | input | XLEN | Return address to store on entry |
| eret_i | input | 1 | Exception return request |
| psr_we_i | input | 1 | Status word write enable |
| psr_wdata_i | input | 8 | Status word write value |
| taken_o | output | 1 | Entry performed at the last edge |
| exc_idx_o | output | 3 | Index of the last exception taken |
| pc_o | output | XLEN | Program counter |
| psr_o | output | 8 | Current status word |

## Verification
Directed walks present every suffix of the request vector, each with masks clear, so every index wins once over all lower-ranked requests. These walks separate priority faults from vector and mode table faults. IRQ-only and FIQ-only requests made under each mask bit, together with reset under full masking, tell mask gating apart from priority selection. Entry-then-return pairs, returns from user mode and a return colliding with a request show whether banking, return gating and operation precedence are correct. Random mixes then change mode, masks and T through status writes, so that saved words and links in every bank are compared with an independent model.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int NUM_EXC  = 7;
    localparam int IDX_W    = $clog2(NUM_EXC);
    localparam int NUM_BANK = 5;
    localparam int BANK_W   = $clog2(NUM_BANK);

    typedef logic [4:0] mode_t;

    localparam mode_t MODE_USR = 5'b10000;
    localparam mode_t MODE_FIQ = 5'b10001;
    localparam mode_t MODE_IRQ = 5'b10010;
    localparam mode_t MODE_SVC = 5'b10011;
    localparam mode_t MODE_ABT = 5'b10111;
    localparam mode_t MODE_UND = 5'b11011;

    // exception index = priority rank (0 highest)
    localparam int EXC_RST  = 0;
    localparam int EXC_DABT = 1;
    localparam int EXC_FIQ  = 2;
    localparam int EXC_IRQ  = 3;
    localparam int EXC_PABT = 4;
    localparam int EXC_UND  = 5;
    localparam int EXC_SWI  = 6;

    typedef struct packed {
        logic  i;
        logic  f;
        logic  t;
        mode_t mode;
    } stat_t;

    localparam int STAT_W = $bits(stat_t);

    typedef struct packed {
        logic              valid;
        logic [BANK_W-1:0] sel;
    } bank_ref_t;

    function automatic bank_ref_t bank_of(input mode_t m);
        bank_ref_t r;
        r.valid = 1'b1;
        unique case (m)
            MODE_FIQ: r.sel = BANK_W'(0);
            MODE_IRQ: r.sel = BANK_W'(1);
            MODE_SVC: r.sel = BANK_W'(2);
            MODE_ABT: r.sel = BANK_W'(3);
            MODE_UND: r.sel = BANK_W'(4);
            default: begin
                r.valid = 1'b0;
                r.sel   = '0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N  = NUM_EXC,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic          irq_mask_i,
    input  logic          fiq_mask_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] live;

    for (genvar g = 0; g < N; g++) begin : g_gate
        if (g == EXC_IRQ) begin : g_irq
            assign live[g] = req_i[g] & ~irq_mask_i;
        end else if (g == EXC_FIQ) begin : g_fiq
            assign live[g] = req_i[g] & ~fiq_mask_i;
        end else begin : g_open
            assign live[g] = req_i[g];
        end
    end

    always_comb begin
        hit_o = |live;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (live[k]) idx_o = IW'(k);
        end
    end

endmodule

// File: rtl/exc_map.sv
module exc_map
    import exc_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output mode_t            mode_o,
    output logic [4:0]       slot_o,
    output logic             set_f_o
);

    always_comb begin
        mode_o  = MODE_SVC;
        slot_o  = 5'h00;
        set_f_o = 1'b0;
        unique case (int'(idx_i))
            EXC_RST:  begin mode_o = MODE_SVC; slot_o = 5'h00; set_f_o = 1'b1; end
            EXC_DABT: begin mode_o = MODE_ABT; slot_o = 5'h10; end
            EXC_FIQ:  begin mode_o = MODE_FIQ; slot_o = 5'h1C; set_f_o = 1'b1; end
            EXC_IRQ:  begin mode_o = MODE_IRQ; slot_o = 5'h18; end
            EXC_PABT: begin mode_o = MODE_ABT; slot_o = 5'h0C; end
            EXC_UND:  begin mode_o = MODE_UND; slot_o = 5'h04; end
            EXC_SWI:  begin mode_o = MODE_SVC; slot_o = 5'h08; end
            default:  begin mode_o = MODE_SVC; slot_o = 5'h00; end
        endcase
    end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
#(
    parameter int NB = NUM_BANK,
    parameter int BW = $clog2(NB),
    parameter int SW = STAT_W,
    parameter int AW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          we_i,
    input  logic [BW-1:0] wsel_i,
    input  logic [SW-1:0] wpsr_i,
    input  logic [AW-1:0] wlink_i,
    input  logic [BW-1:0] rsel_i,
    output logic [SW-1:0] rpsr_o,
    output logic [AW-1:0] rlink_o
);

    logic [SW-1:0] psr_q  [NB];
    logic [AW-1:0] link_q [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                psr_q[b]  <= '0;
                link_q[b] <= '0;
            end else if (we_i && (wsel_i == BW'(b))) begin
                psr_q[b]  <= wpsr_i;
                link_q[b] <= wlink_i;
            end
        end
    end

    always_comb begin
        rpsr_o  = '0;
        rlink_o = '0;
        for (int k = 0; k < NB; k++) begin
            if (rsel_i == BW'(k)) begin
                rpsr_o  = psr_q[k];
                rlink_o = link_q[k];
            end
        end
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_BASE = 32'h0000_0000
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EXC-1:0] exc_req_i,
    input  logic [XLEN-1:0]    link_addr_i,
    input  logic               eret_i,
    input  logic               psr_we_i,
    input  logic [STAT_W-1:0]  psr_wdata_i,
    output logic               taken_o,
    output logic [IDX_W-1:0]   exc_idx_o,
    output logic [XLEN-1:0]    pc_o,
    output logic [STAT_W-1:0]  psr_o
);

    typedef struct packed {
        logic             taken;
        logic [IDX_W-1:0] idx;
        logic [XLEN-1:0]  pc;
        stat_t            psr;
    } core_t;

    localparam stat_t PSR_RESET = '{i: 1'b0, f: 1'b0, t: 1'b0, mode: MODE_USR};

    core_t st_d, st_q;

    logic             win_hit;
    logic [IDX_W-1:0] win_idx;
    mode_t            tgt_mode;
    logic [4:0]       tgt_slot;
    logic             tgt_set_f;
    bank_ref_t        tgt_bank, cur_bank;
    logic             bank_we;
    logic [STAT_W-1:0] bank_rpsr;
    logic [XLEN-1:0]  bank_rlink;

    exc_arbiter #(.N(NUM_EXC), .IW(IDX_W)) u_arb (
        .req_i      (exc_req_i),
        .irq_mask_i (st_q.psr.i),
        .fiq_mask_i (st_q.psr.f),
        .hit_o      (win_hit),
        .idx_o      (win_idx)
    );

    exc_map u_map (
        .idx_i   (win_idx),
        .mode_o  (tgt_mode),
        .slot_o  (tgt_slot),
        .set_f_o (tgt_set_f)
    );

    assign tgt_bank = bank_of(tgt_mode);
    assign cur_bank = bank_of(st_q.psr.mode);
    assign bank_we  = win_hit;

    exc_bank #(.NB(NUM_BANK), .BW(BANK_W), .SW(STAT_W), .AW(XLEN)) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (bank_we),
        .wsel_i  (tgt_bank.sel),
        .wpsr_i  (st_q.psr),
        .wlink_i (link_addr_i),
        .rsel_i  (cur_bank.sel),
        .rpsr_o  (bank_rpsr),
        .rlink_o (bank_rlink)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (win_hit) begin
            st_d.taken    = 1'b1;
            st_d.idx      = win_idx;
            st_d.pc       = XLEN'(VEC_BASE) + XLEN'(tgt_slot);
            st_d.psr.mode = tgt_mode;
            st_d.psr.t    = 1'b0;
            st_d.psr.i    = 1'b1;
            if (tgt_set_f) st_d.psr.f = 1'b1;
        end else if (eret_i && cur_bank.valid) begin
            st_d.psr = stat_t'(bank_rpsr);
            st_d.pc  = bank_rlink;
        end else if (psr_we_i) begin
            st_d.psr = stat_t'(psr_wdata_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.taken <= 1'b0;
            st_q.idx   <= '0;
            st_q.pc    <= XLEN'(VEC_BASE);
            st_q.psr   <= PSR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken_o   = st_q.taken;
    assign exc_idx_o = st_q.idx;
    assign pc_o      = st_q.pc;
    assign psr_o     = st_q.psr;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [31:0] VEC_BASE = 32'h0
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_EXC-1:0] exc_req_i,
    input logic               eret_i,
    input logic               psr_we_i,
    input logic               taken_o,
    input logic [IDX_W-1:0]   exc_idx_o,
    input logic [XLEN-1:0]    pc_o,
    input logic [STAT_W-1:0]  psr_o
);

    a_r2_reset_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_i[0] |=> (taken_o && exc_idx_o == '0));

    a_r3_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psr_o[7] && exc_req_i == 7'b0001000) |=> !taken_o);

    a_r3_fiq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psr_o[6] && exc_req_i == 7'b0000100) |=> !taken_o);

    a_r4_pc_in_table: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> (pc_o[1:0] == 2'b00 && (pc_o - XLEN'(VEC_BASE)) < XLEN'(32)));

    a_r5_entry_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        taken_o |-> (psr_o[7] && !psr_o[5]));

    a_r5_reset_sets_f: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (taken_o && exc_idx_o == '0) |-> psr_o[6]);

    a_r8_idle_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_req_i == '0) |=> !taken_o);

    a_r9_user_return_void: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (psr_o[4:0] == MODE_USR && eret_i && exc_req_i == '0 && !psr_we_i)
            |=> ($stable(psr_o) && $stable(pc_o)));

endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .exc_req_i (exc_req_i),
    .eret_i    (eret_i),
    .psr_we_i  (psr_we_i),
    .taken_o   (taken_o),
    .exc_idx_o (exc_idx_o),
    .pc_o      (pc_o),
    .psr_o     (psr_o)
);

// File: tb/tb_exc_entry_unit.sv
module tb_exc_entry_unit;

    localparam logic [31:0] BASE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [6:0]  req = '0;
    logic [31:0] link = '0;
    logic        eret = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wd = '0;
    logic        taken;
    logic [2:0]  idx;
    logic [31:0] pc;
    logic [7:0]  psr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // independent model
    logic [7:0]  m_psr;
    logic [31:0] m_pc;
    logic [7:0]  m_spsr [5];
    logic [31:0] m_lr   [5];

    always #2.5 clk = ~clk;

    exc_entry_unit #(.XLEN(32), .VEC_BASE(BASE)) dut (
        .clk_i(clk), .rst_ni(rst_ni), .exc_req_i(req), .link_addr_i(link),
        .eret_i(eret), .psr_we_i(we), .psr_wdata_i(wd),
        .taken_o(taken), .exc_idx_o(idx), .pc_o(pc), .psr_o(psr));

    function automatic int winner(input logic [6:0] r, input logic im, input logic fm);
        for (int k = 0; k < 7; k++) begin
            if (r[k] && !(k == 3 && im) && !(k == 2 && fm)) return k;
        end
        return 7;
    endfunction

    function automatic logic [31:0] slot(input int k);
        case (k)
            0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
            4: return 32'h0C; 5: return 32'h04; default: return 32'h08;
        endcase
    endfunction

    function automatic logic [4:0] emode(input int k);
        case (k)
            0, 6: return 5'b10011;
            1, 4: return 5'b10111;
            2: return 5'b10001;
            3: return 5'b10010;
            default: return 5'b11011;
        endcase
    endfunction

    function automatic int mbank(input logic [4:0] m);
        case (m)
            5'b10001: return 0; 5'b10010: return 1; 5'b10011: return 2;
            5'b10111: return 3; 5'b11011: return 4; default: return -1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a negedge; drives inputs, steps model, checks at next negedge
    task automatic step(input logic [6:0] r, input logic er, input logic [31:0] la,
                        input logic w, input logic [7:0] d);
        int k, b;
        logic ent, rt;
        req = r; eret = er; link = la; we = w; wd = d;
        k   = winner(r, m_psr[7], m_psr[6]);
        ent = (k < 7);
        b   = mbank(m_psr[4:0]);
        rt  = !ent && er && (b >= 0);
        if (ent) begin
            b = mbank(emode(k));
            m_spsr[b] = m_psr;
            m_lr[b]   = la;
            m_pc      = BASE + slot(k);
            m_psr     = {1'b1, m_psr[6] | (k == 0 || k == 2), 1'b0, emode(k)};
        end else if (rt) begin
            m_psr = m_spsr[b];
            m_pc  = m_lr[b];
        end else if (w) begin
            m_psr = d;
        end
        @(posedge clk);
        @(negedge clk);
        chk(taken == ent, "R8 taken", 32'(taken), 32'(ent));
        if (ent) begin
            chk(idx == 3'(k), "R2 index", 32'(idx), 32'(k));
            chk(pc == m_pc, "R4 vector", pc, m_pc);
            chk(psr == m_psr, "R5 entry status", 32'(psr), 32'(m_psr));
        end else if (rt) begin
            chk(pc == m_pc, "R7 return pc", pc, m_pc);
            chk(psr == m_psr, "R6 return status", 32'(psr), 32'(m_psr));
        end else begin
            chk(pc == m_pc, "R10 pc unchanged", pc, m_pc);
            chk(psr == m_psr, "R10 status", 32'(psr), 32'(m_psr));
        end
        req = '0; eret = 1'b0; we = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] modes [7];
        logic [31:0] pc0;
        logic [7:0] ps0;
        void'($urandom(32'd1234));
        modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
        m_psr = 8'h10; m_pc = BASE;
        for (int i = 0; i < 5; i++) begin m_spsr[i] = '0; m_lr[i] = '0; end

        repeat (3) @(negedge clk);
        chk(taken == 1'b0 && pc == BASE && psr == 8'h10, "R1 in reset", pc, BASE);
        rst_ni = 1'b1;
        @(negedge clk);
        chk(taken == 1'b0, "R1 taken after reset", 32'(taken), 0);
        chk(pc == BASE, "R1 pc after reset", pc, BASE);
        chk(psr == 8'h10, "R1 status after reset", 32'(psr), 32'h10);

        // R2: each suffix of the request vector, masks cleared first
        for (int k = 0; k < 7; k++) begin
            step('0, 1'b0, '0, 1'b1, 8'h10);
            step(7'h7F << k, 1'b0, 32'h1000 + 32'(k), 1'b0, '0);
        end

        // R3: masked IRQ, masked FIQ, reset under full masking
        step('0, 1'b0, '0, 1'b1, 8'h90);
        step(7'b0001000, 1'b0, 32'h20, 1'b0, '0);
        chk(taken == 1'b0, "R3 irq masked", 32'(taken), 0);
        step('0, 1'b0, '0, 1'b1, 8'h50);
        step(7'b0000100, 1'b0, 32'h24, 1'b0, '0);
        chk(taken == 1'b0, "R3 fiq masked", 32'(taken), 0);
        step('0, 1'b0, '0, 1'b1, 8'hD0);
        step(7'b0000001, 1'b0, 32'h28, 1'b0, '0);
        chk(taken == 1'b1 && idx == 3'd0, "R3 reset unmasked", 32'(idx), 0);

        // R6/R7: entry from user with T set, then return
        step('0, 1'b0, '0, 1'b1, 8'h30);
        step(7'b0100000, 1'b0, 32'hCAFE_0004, 1'b0, '0);
        step('0, 1'b1, '0, 1'b0, '0);
        chk(psr == 8'h30, "R6 saved status restored", 32'(psr), 32'h30);
        chk(pc == 32'hCAFE_0004, "R7 link restored", pc, 32'hCAFE_0004);

        // R9: return in user mode ignored
        pc0 = pc; ps0 = psr;
        step('0, 1'b1, '0, 1'b0, '0);
        chk(pc == pc0 && psr == ps0, "R9 user return ignored", pc, pc0);
        // R9: entry beats return in same cycle
        step(7'b1000000, 1'b0, 32'h44, 1'b0, '0);
        step(7'b0010000, 1'b1, 32'h48, 1'b0, '0);
        chk(taken == 1'b1 && idx == 3'd4, "R9 entry over return", 32'(idx), 4);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [6:0] r;
            int sel;
            sel = int'($urandom_range(0, 9));
            r = (sel < 4) ? 7'($urandom) & 7'($urandom) : '0;
            if (sel == 4) r = 7'(1 << $urandom_range(1, 6));
            step(r, (sel >= 5 && sel <= 7), $urandom,
                 (sel >= 8), {3'($urandom), modes[$urandom_range(0, 6)]});
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule